// File: doc/BRIEF.md
# Serial Polynomial-Division Signature Analyzer

This block compacts a single serial response stream into a short signature by dividing the stream, read as a polynomial, by a fixed characteristic polynomial. It uses a five-stage shift register with the feedback folded in between stages (modular or internal-XOR form). The first bit received is the highest-order coefficient. When the last bit has been shifted in, the register holds the remainder of that division.

A test controller clears the register to all zeros before a run. It then raises the enable for one clock per response bit. After the final bit it reads the signature or the match flag. The match flag compares the live register contents with an expected signature on a separate input. That expected value is the signature a fault-free circuit would give for the same stimulus.

Top module: `serial_sig_analyzer`

## Requirements
- R1: When `clear` is high at a rising edge, `sig` is 5'b00000 after that edge. Bit i of `sig` is stage Xi.
- R2: `clear` has priority over `shift_en`. With both high, `sig` becomes zero whatever the value of `din`.
- R3: While `clear` and `shift_en` are both low, `sig` does not change at any edge, whatever the value of `din`.
- R4: On an enabled edge, `sig[0]` becomes `din` XOR the previous `sig[4]`.
- R5: On an enabled edge, `sig[1]` and `sig[3]` take the previous lower stage XOR the previous `sig[4]`. `sig[2]` and `sig[4]` take the previous lower stage unchanged.
- R6: After clearing and shifting in N bits, `sig` equals the remainder of the input polynomial divided by X^5 + X^3 + X + 1. For example, the stream 1,0,0,0,1,0,1,0 gives `sig` = 5'b01101.
- R7: `match` is high in the same cycle exactly when `sig` equals `expect_sig`, with no clock delay.
- R8: Starting from the cleared state, shifting in zeros leaves `sig` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clear | input | 1 | Synchronous active-high clear to the zero seed |
| shift_en | input | 1 | Shift one bit in on this edge |
| din | input | 1 | Serial response bit, highest order first |
| expect_sig | input | 5 | Fault-free signature to compare against |
| sig | output | 5 | Current register contents, bit i = Xi |
| match | output | 1 | High when `sig` equals `expect_sig` |

## Verification
The division is driven with these streams: the worked eight-bit example, a single leading one that is shorter than the polynomial degree, a lone one followed by fifteen zeros that exercises repeated reduction, all ones, a mixed pattern, and a stream whose only one is in the last bit. The last of these separates the final-bit path from the feedback path. Each final signature is compared with a remainder that the bench works out by long division. This catches a tap in the wrong stage or bits taken in the wrong order. A step-by-step pass checks every stage against the previous observed state, which points to the faulty stage. Directed cases cover clearing while enabled, holding with a toggling input, and a correct signature against one that is off by a single bit.

// File: rtl/sda_pkg.sv
package sda_pkg;
    localparam int SIG_W = 5;
    // bit i set: term X^i present in the divisor (X^5 implied by the feedback)
    localparam logic [SIG_W-1:0] DIV_TAPS = 5'b01011;

    typedef logic [SIG_W-1:0] sig_t;

    typedef struct packed {
        logic wipe;
        logic step;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic clr, input logic en);
        ctl_t c;
        c.wipe = clr;
        c.step = en & ~clr;
        return c;
    endfunction
endpackage

// File: rtl/sda_cell.sv
module sda_cell #(
    parameter bit TAP = 1'b0
) (
    input  logic          clk,
    input  sda_pkg::ctl_t ctl,
    input  logic          from_prev,
    input  logic          fb,
    output logic          q
);
    logic nxt;

    always_comb begin
        nxt = TAP ? (from_prev ^ fb) : from_prev;
    end

    always_ff @(posedge clk) begin
        if (ctl.wipe)      q <= 1'b0;
        else if (ctl.step) q <= nxt;
    end

    generate
        if (!TAP) begin : g_plain_chk
            // R5: untapped stage copies its neighbour
            assert_plain_shift_R5: assert property (@(posedge clk) disable iff (ctl.wipe)
                ctl.step |=> (q == $past(from_prev)));
        end else begin : g_tap_chk
            assert_tap_shift_R5: assert property (@(posedge clk) disable iff (ctl.wipe)
                ctl.step |=> (q == ($past(from_prev) ^ $past(fb))));
        end
    endgenerate
endmodule

// File: rtl/sda_divider.sv
module sda_divider #(
    parameter int                     W    = sda_pkg::SIG_W,
    parameter logic [W-1:0]           TAPS = sda_pkg::DIV_TAPS
) (
    input  logic          clk,
    input  sda_pkg::ctl_t ctl,
    input  logic          din,
    output logic [W-1:0]  state
);
    logic fb;
    logic [W-1:0] feed;

    assign fb = state[W-1];

    always_comb begin
        feed[0] = din;
        for (int i = 1; i < W; i++) feed[i] = state[i-1];
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_stage
            sda_cell #(.TAP(TAPS[g])) u_cell (
                .clk      (clk),
                .ctl      (ctl),
                .from_prev(feed[g]),
                .fb       (fb),
                .q        (state[g])
            );
        end
    endgenerate
endmodule

// File: rtl/sda_compare.sv
module sda_compare #(
    parameter int W = sda_pkg::SIG_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] diff;
    always_comb begin
        diff = a ^ b;
        eq   = ~|diff;
    end
endmodule

// File: rtl/serial_sig_analyzer.sv
module serial_sig_analyzer #(
    parameter int                W    = sda_pkg::SIG_W,
    parameter logic [W-1:0]      TAPS = sda_pkg::DIV_TAPS
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    input  logic [W-1:0] expect_sig,
    output logic [W-1:0] sig,
    output logic         match
);
    localparam int TOP = W - 1;

    sda_pkg::ctl_t ctl;
    always_comb ctl = sda_pkg::decode_ctl(clear, shift_en);

    sda_divider #(.W(W), .TAPS(TAPS)) u_div (
        .clk  (clk),
        .ctl  (ctl),
        .din  (din),
        .state(sig)
    );

    sda_compare #(.W(W)) u_cmp (
        .a (sig),
        .b (expect_sig),
        .eq(match)
    );

    // R1 and R2: a clear edge leaves zero, regardless of enable
    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (clear)
        $past(clear) |-> (sig == '0));
    // R3
    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (clear)
        !shift_en |=> $stable(sig));
    // R4
    assert_entry_bit_R4: assert property (@(posedge clk) disable iff (clear)
        shift_en |=> (sig[0] == ($past(din) ^ $past(sig[TOP]))));
    // R8
    assert_zero_stays_R8: assert property (@(posedge clk) disable iff (clear)
        (shift_en && !din && sig == '0) |=> (sig == '0));
endmodule

// File: tb/serial_sig_analyzer_test.sv
module serial_sig_analyzer_test;
    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       shift_en = 1'b0;
    logic       din = 1'b0;
    logic [4:0] expect_sig = 5'd0;
    logic [4:0] sig;
    logic       match;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    serial_sig_analyzer uut (
        .clk(clk), .clear(clear), .shift_en(shift_en), .din(din),
        .expect_sig(expect_sig), .sig(sig), .match(match)
    );

    localparam int NV = 6;
    localparam logic [15:0] STREAM [NV] = '{16'h008A, 16'h0001, 16'h8000,
                                            16'hFFFF, 16'hA5C3, 16'h0001};
    localparam int          LEN    [NV] = '{8, 1, 16, 16, 16, 16};

    // long division: divisor X^5+X^3+X+1 = 6'b101011
    function automatic logic [4:0] remainder(input logic [15:0] s, input int n);
        logic [5:0] r = 6'd0;
        for (int k = n - 1; k >= 0; k--) begin
            r = {r[4:0], s[k]};
            if (r[5]) r = r ^ 6'b101011;
        end
        return r[4:0];
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1; shift_en = 1'b0;
        @(negedge clk); clear = 1'b0;
    endtask

    task automatic feed(input logic [15:0] s, input int n);
        for (int k = n - 1; k >= 0; k--) begin
            shift_en = 1'b1; din = s[k];
            @(negedge clk);
        end
        shift_en = 1'b0; din = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] prev, want;
        // reset state, R1
        repeat (2) @(negedge clk);
        check("R1 reset", sig, 5'd0);
        expect_sig = 5'd0;
        check("R7 match at zero", {4'd0, match}, 5'd1);
        clear = 1'b0;

        // table walk, R6 and R7
        for (int v = 0; v < NV; v++) begin
            do_clear();
            feed(STREAM[v], LEN[v]);
            want = remainder(STREAM[v], LEN[v]);
            check($sformatf("R6 vector %0d", v), sig, want);
            expect_sig = want; #1;
            check("R7 match equal", {4'd0, match}, 5'd1);
            expect_sig = want ^ 5'b10000; #1;
            check("R7 match off by one bit", {4'd0, match}, 5'd0);
        end

        // worked example constant, R6
        do_clear(); feed(16'h008A, 8);
        check("R6 worked example", sig, 5'b01101);

        // stepwise stage rules, R4 and R5
        do_clear();
        for (int k = 15; k >= 0; k--) begin
            prev = sig;
            shift_en = 1'b1; din = STREAM[4][k];
            @(negedge clk);
            want[0] = STREAM[4][k] ^ prev[4];
            want[1] = prev[0] ^ prev[4];
            want[2] = prev[1];
            want[3] = prev[2] ^ prev[4];
            want[4] = prev[3];
            check("R4 entry stage", {4'd0, sig[0]}, {4'd0, want[0]});
            check("R5 inner stages", {sig[4:1], 1'b0}, {want[4:1], 1'b0});
        end
        shift_en = 1'b0;

        // hold with toggling din, R3
        prev = sig;
        for (int k = 0; k < 6; k++) begin
            din = k[0]; @(negedge clk);
        end
        check("R3 hold while disabled", sig, prev);

        // clear beats enable, R2
        clear = 1'b1; shift_en = 1'b1; din = 1'b1;
        @(negedge clk);
        check("R2 clear priority", sig, 5'd0);
        clear = 1'b0; shift_en = 1'b0;

        // clear mid-stream, R1
        feed(16'h00F3, 8);
        do_clear();
        check("R1 clear mid-stream", sig, 5'd0);

        // zeros from zero seed, R8
        feed(16'h0000, 12);
        check("R8 zero stream", sig, 5'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule